// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver with Four-Entry Queue

This block takes an asynchronous serial line that idles high and turns each 10-bit character into a byte. A character is one low start bit, eight data bits with the least significant bit first, and one high stop bit. Timing comes from a strobe, `os_tick`, that pulses for one clock four times per bit period. The block does not generate that strobe. The line passes through a two-flop synchronizer. A falling edge seen while the receiver is idle begins a character. At that moment the position of the tick within its cycle of four is latched. From then on every bit is sampled on the tick that lies two quarter-periods after the recorded position. This puts the sample point between half and three-quarters of the way through each bit.

When the stop bit has been sampled, the receiver checks both framing bits and offers the byte to a four-deep first-in first-out queue. The host sees the oldest byte on `q_data` and removes it with a one-clock `q_pop` strobe. The queue reports empty, full, and one-short-of-full. A character that completes while the queue is full is dropped and raises `ovf_evt`. A character with a bad start or stop bit raises `frm_err_evt` and is still stored.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `q_empty` is 1, `q_full` and `q_full_m1` are 0, and neither event output is active.
- R2: A character begins only on a synchronized high-to-low transition of `rx_line` while idle. A line that stays high stores nothing. The receiver is idle again once the stop bit has been sampled.
- R3: Each bit is sampled on the `os_tick` pulse that comes two quarter-periods after the tick position latched at the start edge, and on every fourth tick after that. A correct byte is recovered at any start-edge offset relative to the tick.
- R4: Data bits are assembled least significant bit first. The first data bit after the start bit becomes bit 0 of the byte.
- R5: A character whose sampled start bit is 1 or whose sampled stop bit is 0 produces a single-clock pulse on `frm_err_evt`. If the queue has space, the byte is still stored. A well-formed character produces no pulse.
- R6: The queue holds up to 4 bytes and returns them in arrival order. `q_data` always shows the oldest byte while `q_empty` is 0.
- R7: `q_empty` is 1 whenever the queue holds no byte. It clears when a byte is stored and sets again when the last byte is popped.
- R8: `q_full` is 1 exactly when 4 bytes are held. `q_full_m1` is 1 exactly when 3 bytes are held.
- R9: If a character completes while the queue holds 4 bytes, `ovf_evt` pulses for one clock, the new byte is discarded, and the stored bytes stay unchanged.
- R10: A `q_pop` while the queue is empty has no effect. The queue stays empty and a later byte is stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-clock strobe, four per bit period |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| q_pop | input | 1 | Removes the oldest byte from the queue |
| q_data | output | 8 | Oldest byte held in the queue |
| q_empty | output | 1 | Queue holds no byte |
| q_full | output | 1 | Queue holds 4 bytes |
| q_full_m1 | output | 1 | Queue holds 3 bytes |
| ovf_evt | output | 1 | One-clock pulse when a byte is dropped on a full queue |
| frm_err_evt | output | 1 | One-clock pulse when a character has a bad start or stop bit |

## Verification
Two kinds of internal fault show up at the ports:
- **Wrong latched tick phase or wrong bit counter.** The byte appears with its bits shifted, or a framing error appears on a clean character. Both are visible one character time later, on `q_data` and `frm_err_evt`.
- **Wrong queue pointer or occupancy count.** `q_data` shows bytes out of order, or the three flags disagree with the number of bytes sent minus those popped. This is visible at the very next pop or store.

An overflow that overwrites stored data instead of dropping the new byte stays hidden until the queue is drained. For that reason the queue is always emptied completely after each overflow.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int OSR     = 4;
  localparam int PH_W    = $clog2(OSR);
  localparam int DATA_W  = 8;
  localparam int FRAME_N = DATA_W + 2;

  typedef enum logic {RX_IDLE, RX_BUSY} rx_state_t;

  // Tick position at which a bit is sampled, given the position at the start edge.
  function automatic logic [PH_W-1:0] sample_phase(input logic [PH_W-1:0] edge_ph);
    return edge_ph + PH_W'(OSR / 2);
  endfunction

  // Start bit must be low and stop bit high.
  function automatic logic framing_ok(input logic start_b, input logic stop_b);
    return (start_b == 1'b0) && (stop_b == 1'b1);
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              line_s,
  output logic              char_done,
  output logic [DATA_W-1:0] char_byte,
  output logic              char_ok
);
  localparam int IDX_W = $clog2(FRAME_N + 1);

  rx_state_t          state;
  logic [PH_W-1:0]    tick_ph;
  logic [PH_W-1:0]    edge_ph;
  logic [IDX_W-1:0]   bit_idx;
  logic [FRAME_N-1:0] shreg;
  logic               line_d;
  logic               done_q;

  // Named internal events for the assertions.
  logic start_edge;
  logic sample_en;
  logic last_bit;

  assign start_edge = (state == RX_IDLE) && line_d && !line_s;
  assign sample_en  = (state == RX_BUSY) && os_tick && (tick_ph == sample_phase(edge_ph));
  assign last_bit   = sample_en && (bit_idx == IDX_W'(FRAME_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      tick_ph <= '0;
      edge_ph <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      line_d  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      line_d <= line_s;
      done_q <= last_bit;
      if (os_tick) tick_ph <= tick_ph + 1'b1;
      if (start_edge) begin
        state   <= RX_BUSY;
        edge_ph <= tick_ph;
        bit_idx <= '0;
      end else if (sample_en) begin
        shreg   <= {line_s, shreg[FRAME_N-1:1]};
        bit_idx <= bit_idx + 1'b1;
        if (last_bit) state <= RX_IDLE;
      end
    end
  end

  assign char_done = done_q;
  assign char_byte = shreg[FRAME_N-2:1];
  assign char_ok   = framing_ok(shreg[0], shreg[FRAME_N-1]);

  // R3: the latched tick position holds for the whole character.
  a_r3_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_BUSY) && $past(state == RX_BUSY) |-> $stable(edge_ph));
  // R2: idle again once the stop bit is sampled.
  a_r2_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |-> state == RX_IDLE);
  // R2: while busy, a falling line never restarts the character.
  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_BUSY) && !sample_en |=> $stable(bit_idx));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic          full_m1,
  output logic          overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign full_m1  = (cnt == CW'(DEPTH - 1));
  assign do_push  = push_req && !full;
  assign do_pop   = pop_req && !empty;
  assign overflow = push_req && full;
  assign head     = mem[rptr];

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (do_push && wptr == AW'(i)) mem[i] <= push_data;
      end
    end
  endgenerate

  // R8: full and full-minus-one are never both set.
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && full_m1));
  // R7: a stored byte clears empty.
  a_r7_push_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && !overflow |=> !empty);
  // R9: a dropped byte leaves the queue full and the head unchanged.
  a_r9_overflow_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !pop_req |=> full && $stable(head));
  // R10: popping an empty queue leaves it empty.
  a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop_req && !push_req |=> empty);
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx
  import uart_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int Q_DEPTH     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic              q_pop,
  output logic [DATA_W-1:0] q_data,
  output logic              q_empty,
  output logic              q_full,
  output logic              q_full_m1,
  output logic              ovf_evt,
  output logic              frm_err_evt
);
  logic              line_s;
  logic              char_done;
  logic              char_ok;
  logic [DATA_W-1:0] char_byte;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(rx_line), .sync_out(line_s));

  uart_rx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_s(line_s),
    .char_done(char_done), .char_byte(char_byte), .char_ok(char_ok));

  uart_rx_fifo #(.DW(DATA_W), .DEPTH(Q_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_req(char_done), .push_data(char_byte),
    .pop_req(q_pop), .head(q_data), .empty(q_empty), .full(q_full),
    .full_m1(q_full_m1), .overflow(ovf_evt));

  assign frm_err_evt = char_done && !char_ok;

  // R5: framing and overflow events are single-clock pulses.
  a_r5_ferr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err_evt |=> !frm_err_evt);
  // R9: overflow event is a single-clock pulse.
  a_r9_ovf_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> !ovf_evt);
endmodule

// File: tb/tb_uart_os_rx.sv
module tb_uart_os_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 8;
  localparam int BIT_CLKS   = 4 * TICK_DIV;
  localparam int DEPTH      = 4;

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rx_line = 1'b1, q_pop = 1'b0;
  logic [7:0] q_data;
  logic q_empty, q_full, q_full_m1, ovf_evt, frm_err_evt;

  int checks = 0, errors = 0, ovf_cnt = 0, ferr_cnt = 0, tdiv = 0;
  bit finished = 1'b0;
  logic [7:0] model[$];

  uart_os_rx dut (.clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .q_pop(q_pop), .q_data(q_data), .q_empty(q_empty), .q_full(q_full),
    .q_full_m1(q_full_m1), .ovf_evt(ovf_evt), .frm_err_evt(frm_err_evt));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == TICK_DIV - 1);
  end

  always @(posedge clk) begin
    if (rst_n && ovf_evt)     ovf_cnt  <= ovf_cnt + 1;
    if (rst_n && frm_err_evt) ferr_cnt <= ferr_cnt + 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected flags from the model occupancy.
  function automatic logic [2:0] exp_flags(int n);
    return {n == 0, n == DEPTH, n == DEPTH - 1};
  endfunction

  task automatic check_flags(string req);
    @(negedge clk);
    check(req, {q_empty, q_full, q_full_m1}, exp_flags(model.size()));
    if (model.size() > 0) check(req, q_data, model[0]);
  endtask

  task automatic send(logic [7:0] b, logic stop_b);
    logic [9:0] fr;
    repeat ($urandom_range(0, 40)) @(negedge clk);
    fr = {stop_b, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx_line = fr[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  // Expected queue update for a completed character.
  task automatic model_push(logic [7:0] b, output bit dropped);
    dropped = (model.size() == DEPTH);
    if (!dropped) model.push_back(b);
  endtask

  task automatic pop;
    @(negedge clk); q_pop = 1'b1;
    @(negedge clk); q_pop = 1'b0;
    if (model.size() > 0) void'(model.pop_front());
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int o, f;
    bit d;
    logic [7:0] b;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {q_empty, q_full, q_full_m1, ovf_evt, frm_err_evt}, 5'b10000);
    // R2 idle line stores nothing
    repeat (20 * BIT_CLKS) @(negedge clk);
    check("R2", q_empty, 1'b1);
    // R4 lsb first
    send(8'h01, 1'b1); model_push(8'h01, d);
    check_flags("R4");
    check("R4", q_data, 8'h01);
    pop(); check_flags("R7");
    // R10 pop on empty, then a byte stores normally
    pop(); check_flags("R10");
    send(8'hA5, 1'b1); model_push(8'hA5, d);
    check_flags("R10");
    pop();
    check("R5 clean", ferr_cnt, 0);
    // R3 random bytes at random tick offsets; R6/R8 fill, R9 overflow
    for (int round = 0; round < 4; round++) begin
      o = ovf_cnt;
      for (int k = 0; k < DEPTH + 1; k++) begin
        b = 8'($urandom());
        send(b, 1'b1); model_push(b, d);
        check_flags("R8");
        check(d ? "R9" : "R3", ovf_cnt, o + (d ? 1 : 0));
        o = ovf_cnt;
      end
      while (model.size() > 0) begin
        check("R6", q_data, model[0]);
        pop();
        check_flags("R7");
      end
    end
    // R5 bad stop bit: pulse and byte still stored
    f = ferr_cnt;
    send(8'h3C, 1'b0); model_push(8'h3C, d);
    check("R5 stop", ferr_cnt, f + 1);
    check_flags("R5");
    pop();
    // R5 short glitch: start sample reads 1, all ones stored
    f = ferr_cnt;
    repeat ($urandom_range(0, 40)) @(negedge clk);
    rx_line = 1'b0; repeat (4) @(negedge clk); rx_line = 1'b1;
    repeat (11 * BIT_CLKS) @(negedge clk);
    model_push(8'hFF, d);
    check("R5 start", ferr_cnt, f + 1);
    check_flags("R5");
    pop(); check_flags("R7");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule